// File: doc/BRIEF.md
# Initiation-Interval Loop Issue Controller

This block sequences the innermost loop of a pipelined datapath body. When enabled it walks a loop index upward from zero and stops one short of a bound. It issues one iteration at a time and spaces the issues a fixed number of cycles apart, the initiation interval. For each issue it raises a single-cycle datapath-enable strobe, and the current index sits beside it. The strobe is the qualifier that the body uses for its memory read and write enables. The body itself is not part of the block. The controller follows every issued iteration through a shadow pipeline as deep as the body latency. It pulses done when the final iteration reaches the last stage of that pipeline.

A mode input turns on stream operation. In this mode an iteration may only issue while the upstream valid is high. A low downstream ready freezes the whole body: nothing issues, the index holds, the interval countdown stops and the latency tracking stops. Once done has pulsed, the controller stays quiet until enable has been dropped and raised again.

Top module: `iiloop_ctrl`

## Requirements
- R1: After reset, with enable low, `dpEn` and `done` are 0 and `idx` is 0.
- R2: When idle, the first issue comes in the same cycle in which enable is first seen high. Later issues are at least II cycles apart, and exactly II apart when nothing stalls (II defaults to 3).
- R3: A run with bound N issues exactly N times, and `idx` reads 0, 1, ..., N-1 on successive `dpEn` cycles.
- R4: `done` is high exactly LAT unfrozen cycles after the last issue (LAT defaults to 4). A single-iteration run with no stalls therefore shows `done` LAT cycles after enable is seen.
- R5: `done` is a one-cycle pulse. After it, while enable stays high, no issue and no further `done` occur. A new run starts only after enable goes low and then high again.
- R6: A bound of zero issues nothing and pulses `done` in the cycle after enable is first seen.
- R7: With `streamMode` = 1, an issue happens only in a cycle where `inValid` = 1. The interval countdown keeps running while `inValid` is low.
- R8: With `streamMode` = 1 and `outReady` = 0, there is no issue, no index step and no countdown, and the in-flight latency tracking holds. `done` is not driven, so it is deferred by the number of frozen cycles.
- R9: With `streamMode` = 0, `inValid` and `outReady` have no effect on issue or `done` timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts a run when seen high in idle |
| streamMode | input | 1 | 1 = issue gated by `inValid`, body frozen by low `outReady` |
| bound | input | CNT_W | Iteration count, captured at start |
| inValid | input | 1 | Upstream stream valid (forward pressure) |
| outReady | input | 1 | Downstream stream ready (backpressure) |
| dpEn | output | 1 | Datapath-enable strobe, one cycle per issued iteration |
| idx | output | CNT_W | Loop index of the iteration being issued |
| done | output | 1 | One-cycle pulse when the last iteration leaves the body |

## Verification
The hardest case to reach is a freeze that overlaps the in-flight pipeline in two different ways. In one, the freeze lands while the interval countdown is part way through. In the other, it lands in the very cycle when the last iteration would have produced `done`. Each vector in the bench drives `outReady` low over a chosen window of cycles counted from the start of the run. The windows are placed just after an issue and exactly on the expected `done` cycle. The bench then checks that every later issue, and `done`, moves by precisely the frozen length. Other vectors hold `inValid` low across the cycle in which the countdown expires. This shows that the next issue lands on the first valid cycle and not a full interval later.

// File: rtl/iiloop_pkg.sv
package iiloop_pkg;

  typedef struct packed {
    logic issue;
    logic issueLast;
    logic clear;
    logic load;
  } ctrl_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_EMPTY,
    ST_HOLD
  } ctrl_state_t;

endpackage

// File: rtl/iiloop_datapath.sv
module iiloop_datapath
  import iiloop_pkg::*;
#(
  parameter int II    = 3,
  parameter int LAT   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic             freeze,
  input  logic [CNT_W-1:0] bound,
  output logic [CNT_W-1:0] idx,
  output logic             gapReady,
  output logic             atLast,
  output logic             boundZero,
  output logic             tailDone
);

  localparam int GAP_W = (II > 1) ? $clog2(II + 1) : 1;
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(II - 1);

  logic [CNT_W-1:0] boundQ;
  logic [CNT_W-1:0] effBound;
  logic [GAP_W-1:0] gapCnt;
  logic [LAT-1:0]   vldPipe, vldNext;
  logic [LAT-1:0]   lastPipe, lastNext;

  // iteration count: taken from the port in the start cycle, held after
  assign effBound  = strobe.load ? bound : boundQ;
  assign atLast    = (idx == effBound - CNT_W'(1));
  assign boundZero = (bound == '0);
  assign gapReady  = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boundQ <= '0;
    end else if (strobe.load) begin
      boundQ <= bound;
    end
  end

  // loop index
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      idx <= '0;
    end else if (strobe.issue) begin
      idx <= idx + CNT_W'(1);
    end
  end

  // initiation-interval countdown, held while the body is frozen
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      gapCnt <= '0;
    end else if (!freeze) begin
      if (strobe.issue) begin
        gapCnt <= GAP_RELOAD;
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - GAP_W'(1);
      end
    end
  end

  // shadow of the body: one valid bit and one last-iteration bit per stage
  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign vldNext[g]  = strobe.issue;
      assign lastNext[g] = strobe.issueLast;
    end else begin : g_body
      assign vldNext[g]  = vldPipe[g-1];
      assign lastNext[g] = lastPipe[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe  <= '0;
      lastPipe <= '0;
    end else if (!freeze) begin
      vldPipe  <= vldNext;
      lastPipe <= lastNext;
    end
  end

  assign tailDone = vldPipe[LAT-1] & lastPipe[LAT-1] & ~freeze;

endmodule

// File: rtl/iiloop_control.sv
module iiloop_control
  import iiloop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         streamMode,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         gapReady,
  input  logic         atLast,
  input  logic         boundZero,
  input  logic         tailDone,
  output ctrl_strobe_t strobe,
  output logic         freeze,
  output logic         done
);

  ctrl_state_t state, stateNext;
  logic        canIssue;

  assign freeze   = streamMode & ~outReady;
  assign canIssue = gapReady & ~freeze & (~streamMode | inValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobe    = '0;
    done      = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (enable) begin
          strobe.load = 1'b1;
          if (boundZero) begin
            stateNext = ST_EMPTY;
          end else if (canIssue) begin
            strobe.issue     = 1'b1;
            strobe.issueLast = atLast;
            stateNext        = atLast ? ST_DRAIN : ST_RUN;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (canIssue) begin
          strobe.issue     = 1'b1;
          strobe.issueLast = atLast;
          if (atLast) begin
            stateNext = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (tailDone) begin
          done      = 1'b1;
          stateNext = ST_HOLD;
        end
      end
      ST_EMPTY: begin
        done      = 1'b1;
        stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (!enable) begin
          strobe.clear = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/iiloop_ctrl.sv
module iiloop_ctrl
  import iiloop_pkg::*;
#(
  parameter int II    = 3,
  parameter int LAT   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             streamMode,
  input  logic [CNT_W-1:0] bound,
  input  logic             inValid,
  input  logic             outReady,
  output logic             dpEn,
  output logic [CNT_W-1:0] idx,
  output logic             done
);

  ctrl_strobe_t strobe;
  logic         freeze;
  logic         gapReady;
  logic         atLast;
  logic         boundZero;
  logic         tailDone;

  iiloop_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .streamMode (streamMode),
    .inValid    (inValid),
    .outReady   (outReady),
    .gapReady   (gapReady),
    .atLast     (atLast),
    .boundZero  (boundZero),
    .tailDone   (tailDone),
    .strobe     (strobe),
    .freeze     (freeze),
    .done       (done)
  );

  iiloop_datapath #(
    .II    (II),
    .LAT   (LAT),
    .CNT_W (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .freeze    (freeze),
    .bound     (bound),
    .idx       (idx),
    .gapReady  (gapReady),
    .atLast    (atLast),
    .boundZero (boundZero),
    .tailDone  (tailDone)
  );

  assign dpEn = strobe.issue;

endmodule

// File: rtl/iiloop_ctrl_chk.sv
module iiloop_ctrl_chk #(
  parameter int II = 3
) (
  input logic clk,
  input logic rstN,
  input logic streamMode,
  input logic inValid,
  input logic outReady,
  input logic dpEn,
  input logic done
);

  localparam int SW = $clog2(II + 1) + 1;

  logic [SW-1:0] sinceIssue;

  // cycles since the last issue, saturating at II
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceIssue <= SW'(II);
    end else if (dpEn) begin
      sinceIssue <= SW'(1);
    end else if (sinceIssue < SW'(II)) begin
      sinceIssue <= sinceIssue + SW'(1);
    end
  end

  p_issue_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    dpEn |-> (sinceIssue >= SW'(II)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !dpEn);

  p_valid_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (streamMode && dpEn) |-> inValid);

  p_frozen_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (streamMode && !outReady) |-> (!dpEn && !done));

endmodule

bind iiloop_ctrl iiloop_ctrl_chk #(.II(II)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .streamMode (streamMode),
  .inValid    (inValid),
  .outReady   (outReady),
  .dpEn       (dpEn),
  .done       (done)
);

// File: tb/sim_iiloop_ctrl.sv
`timescale 1ns/1ps
module sim_iiloop_ctrl;

  localparam int II      = 3;
  localparam int LAT     = 4;
  localparam int CNT_W   = 8;
  localparam int NONE    = 1000;
  localparam int HORIZON = 40;
  localparam int NV      = 11;

  typedef struct packed {
    int sm;
    int bnd;
    int vLo;
    int vHi;
    int rLo;
    int rHi;
    int eFirst;
    int eLast;
    int eDone;
  } vec_t;

  // sm, bound, inValid-low window, outReady-low window, first, last, done
  localparam vec_t VECS [NV] = '{
    '{0, 1, NONE, NONE, NONE, NONE,  0,  0,  4},
    '{0, 2, NONE, NONE, NONE, NONE,  0,  3,  7},
    '{0, 5, NONE, NONE, NONE, NONE,  0, 12, 16},
    '{0, 7, NONE, NONE, NONE, NONE,  0, 18, 22},
    '{0, 2,    0, NONE,    0, NONE,  0,  3,  7},
    '{1, 2,    0,    4, NONE, NONE,  5,  8, 12},
    '{1, 1, NONE, NONE,    2,    4,  0,  0,  7},
    '{1, 3, NONE, NONE,    1,    2,  0,  8, 12},
    '{1, 1, NONE, NONE,    4,    5,  0,  0,  6},
    '{1, 2,    3,    6, NONE, NONE,  0,  7, 11},
    '{0, 0, NONE, NONE, NONE, NONE, -1, -1,  1}
  };

  logic             clk;
  logic             rstN;
  logic             enable;
  logic             streamMode;
  logic [CNT_W-1:0] bound;
  logic             inValid;
  logic             outReady;
  logic             dpEn;
  logic [CNT_W-1:0] idx;
  logic             done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  iiloop_ctrl #(.II(II), .LAT(LAT), .CNT_W(CNT_W)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .streamMode (streamMode),
    .bound      (bound),
    .inValid    (inValid),
    .outReady   (outReady),
    .dpEn       (dpEn),
    .idx        (idx),
    .done       (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string vecTag(input int n);
    case (n)
      0:       return "R4";
      4:       return "R9";
      5, 9:    return "R7";
      6, 7, 8: return "R8";
      10:      return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic runVec(input int n);
    vec_t  v = VECS[n];
    string t = $sformatf("%s v%0d", vecTag(n), n);
    int cnt = 0, dcnt = 0, dAt = -1, firstAt = -1, lastAt = -1;
    int prevAt = -1, minGap = NONE, badIdx = 0, postDone = 0;
    bound      = CNT_W'(v.bnd);
    streamMode = v.sm[0];
    for (int c = 0; c < HORIZON; c++) begin
      @(negedge clk);
      enable   = 1'b1;
      inValid  = !(c >= v.vLo && c <= v.vHi);
      outReady = !(c >= v.rLo && c <= v.rHi);
      #1;
      if (dpEn) begin
        if (int'(idx) != cnt) badIdx++;
        if (prevAt >= 0 && c - prevAt < minGap) minGap = c - prevAt;
        if (firstAt < 0) firstAt = c;
        lastAt = c;
        prevAt = c;
        cnt++;
        if (dcnt > 0) postDone++;
      end
      if (done) begin
        dcnt++;
        if (dAt < 0) dAt = c;
      end
    end
    @(negedge clk);
    enable   = 1'b0;
    inValid  = 1'b1;
    outReady = 1'b1;
    @(negedge clk);
    chk($sformatf("R3 issue count %s", t), cnt, v.bnd);
    chk($sformatf("R3 index order %s", t), badIdx, 0);
    if (v.bnd > 0) begin
      chk($sformatf("R2 first issue cycle %s", t), firstAt, v.eFirst);
      chk($sformatf("R2 last issue cycle %s", t), lastAt, v.eLast);
    end
    if (cnt > 1) chk($sformatf("R2 spacing at least II %s", t), int'(minGap >= II), 1);
    chk($sformatf("R4 done cycle %s", t), dAt, v.eDone);
    chk($sformatf("R5 done pulse count %s", t), dcnt, 1);
    chk($sformatf("R5 quiet after done %s", t), postDone, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN       = 1'b0;
    enable     = 1'b0;
    streamMode = 1'b0;
    bound      = '0;
    inValid    = 1'b1;
    outReady   = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 dpEn in reset", int'(dpEn), 0);
    chk("R1 done in reset", int'(done), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 dpEn idle after reset", int'(dpEn), 0);
    chk("R1 done idle after reset", int'(done), 0);
    chk("R1 idx after reset", int'(idx), 0);

    for (int n = 0; n < NV; n++) begin
      runVec(n);
    end

    // restart after the zero-bound run: one plain run again
    runVec(1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule